// File: doc/BRIEF.md
# External Interrupt Request Latch Unit

This block watches eight external request pins. Each pin passes through a synchroniser, and a rising edge on the synchronised level is caught in a per-channel pending flag. The flag stays set until software clears it. Each channel drives a registered interrupt request toward an interrupt controller. That request is the channel's flag gated by its enable bit. A single combined request line is the OR of all eight channels.

Software sees one 16-bit word through a simple register port with byte strobes. The low byte at byte address 0x38 holds the channel enables. The high byte at 0x39 holds the pending flags. Flags are cleared by writing 0 to them; writing 1 leaves them alone. A sideband input marks the read half of a read-modify-write access. During that read the flag byte reads as all ones, so the write-back that follows cannot clear a flag by accident. Flags are captured whether or not the channel is enabled. Setting an enable never clears a flag, so software clears the flag itself just before enabling the channel.

The flag bank resets to zero. This fixed value is chosen so that the bank has a known state after reset.

Top module: `eirq_latch_unit`

## Requirements
- R1: After reset the enable byte is 0x00, the flag byte is 0x00, and every `irq_ch` bit and `irq_any` are 0.
- R2: A 0-to-1 transition on `ext_pin[i]` sets flag bit i. The flag can be read three clock edges after the pin rises, and it stays set after the pin falls. If the pin is held high, the flag is not set again once it has been cleared.
- R3: A write with `bus_be[1]`=1 clears every flag bit i for which `bus_wdata[8+i]` is 0. Flag bits written with 1 keep their value.
- R4: A read of the word gives the enables on `bus_rdata[7:0]`. On `bus_rdata[15:8]` it gives the flags, or 0xFF when `bus_rmw`=1.
- R5: `irq_ch[i]` is the registered AND of flag bit i and enable bit i. A flag is latched while its enable bit is 0, and no request is raised for it.
- R6: `irq_any` is 1 exactly when at least one channel's flag AND enable was true one cycle earlier, which is the OR of `irq_ch`.
- R7: A write with only `bus_be[0]`=1 updates the enables from `bus_wdata[7:0]` and leaves the flags unchanged. A write with only `bus_be[1]`=1 leaves the enables unchanged.
- R8: If a new edge on pin i and a software clear of flag i fall in the same cycle, flag i ends up set.
- R9: Writing 1 to an enable bit whose flag is already set does not clear that flag, and the request appears on `irq_ch`.
- R10: Accesses whose word address differs from that of 0x38, or that have `bus_sel`=0, read as 0x0000 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 8 | Asynchronous external request pins |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address (word decoded) |
| bus_be | input | 2 | Byte strobes: bit 0 low byte, bit 1 high byte |
| bus_wdata | input | 16 | Write data |
| bus_rmw | input | 1 | Read half of a read-modify-write access |
| bus_rdata | output | 16 | Read data (combinational) |
| irq_ch | output | 8 | Per-channel interrupt requests |
| irq_any | output | 1 | OR of all channel requests |

## Verification
Single pin pulses are applied on disabled and enabled channels. This separates flag latching from request gating, and it shows that enabling a channel with a pending flag raises the request without clearing the flag. Clear words with mixed 0 and 1 bits show that clears work per bit. Reads with and without the read-modify-write marker, and strobe-only writes, show that the byte lanes are kept apart. A pin held high across a clear tells edge detection from level detection. A fresh edge placed in the same cycle as a clear fixes the priority between the two, and accesses to a neighbouring word confirm the address decode.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_CH = BYTE_W;
  localparam int DATA_W = 2 * BYTE_W;
  localparam int BE_W   = DATA_W / BYTE_W;

  typedef struct packed {
    logic              wr_lo;
    logic              wr_hi;
    logic [BYTE_W-1:0] wd_lo;
    logic [BYTE_W-1:0] wd_hi;
  } reg_wr_t;
endpackage

// File: rtl/eirq_pin_sync.sv
module eirq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  always_comb begin
    sync_d[0] = pin_async;
    for (int s = 1; s < STAGES; s++) begin
      sync_d[s] = sync_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/eirq_regif.sv
module eirq_regif
  import eirq_pkg::*;
#(
  parameter int             ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0038
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rmw,
  input  logic [NUM_CH-1:0] flags,
  input  logic [NUM_CH-1:0] enables,
  output reg_wr_t           wr_req,
  output logic [DATA_W-1:0] bus_rdata
);
  logic hit;
  logic rd_hit;
  logic wr_hit;

  assign hit    = bus_sel && (bus_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
  assign rd_hit = hit && !bus_wr;
  assign wr_hit = hit && bus_wr;

  always_comb begin
    wr_req.wr_lo = wr_hit && bus_be[0];
    wr_req.wr_hi = wr_hit && bus_be[1];
    wr_req.wd_lo = bus_wdata[BYTE_W-1:0];
    wr_req.wd_hi = bus_wdata[DATA_W-1:BYTE_W];
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      bus_rdata[BYTE_W-1:0] = enables;
      if (bus_rmw) begin
        bus_rdata[DATA_W-1:BYTE_W] = '1;
      end else begin
        bus_rdata[DATA_W-1:BYTE_W] = flags;
      end
    end
  end
endmodule

// File: rtl/eirq_flag_bank.sv
module eirq_flag_bank
  import eirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] rise,
  input  reg_wr_t           wr_req,
  output logic [NUM_CH-1:0] flags,
  output logic [NUM_CH-1:0] enables,
  output logic [NUM_CH-1:0] irq_ch,
  output logic              irq_any
);
  logic [NUM_CH-1:0] flag_q, flag_d;
  logic [NUM_CH-1:0] en_q, en_d;
  logic [NUM_CH-1:0] irq_q, irq_d;
  logic              any_q, any_d;
  logic [NUM_CH-1:0] clr_mask;

  always_comb begin
    clr_mask = wr_req.wr_hi ? ~wr_req.wd_hi : '0;
    flag_d   = (flag_q & ~clr_mask) | rise;
    en_d     = wr_req.wr_lo ? wr_req.wd_lo : en_q;
    irq_d    = flag_q & en_q;
    any_d    = |(flag_q & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      irq_q  <= '0;
      any_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
      irq_q  <= irq_d;
      any_q  <= any_d;
    end
  end

  assign flags   = flag_q;
  assign enables = en_q;
  assign irq_ch  = irq_q;
  assign irq_any = any_q;
endmodule

// File: rtl/eirq_latch_unit.sv
module eirq_latch_unit
  import eirq_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h0038,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ext_pin,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rmw,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq_ch,
  output logic              irq_any
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [NUM_CH-1:0] rise;
  logic [NUM_CH-1:0] flags;
  logic [NUM_CH-1:0] enables;
  reg_wr_t           wr_req;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_pin
    eirq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .pin_async (ext_pin[g]),
      .rise      (rise[g])
    );
  end

  eirq_regif #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regif (
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rmw   (bus_rmw),
    .flags     (flags),
    .enables   (enables),
    .wr_req    (wr_req),
    .bus_rdata (bus_rdata)
  );

  eirq_flag_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rise    (rise),
    .wr_req  (wr_req),
    .flags   (flags),
    .enables (enables),
    .irq_ch  (irq_ch),
    .irq_any (irq_any)
  );
endmodule

// File: rtl/eirq_latch_unit_chk.sv
module eirq_latch_unit_chk
  import eirq_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0038
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BE_W-1:0]   bus_be,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rmw,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] rise,
  input logic [NUM_CH-1:0] flags,
  input logic [NUM_CH-1:0] enables,
  input logic [NUM_CH-1:0] irq_ch,
  input logic              irq_any
);
  logic hit, wr_lo, wr_hi, rd_rmw;
  assign hit    = bus_sel && (bus_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
  assign wr_lo  = hit && bus_wr && bus_be[0];
  assign wr_hi  = hit && bus_wr && bus_be[1];
  assign rd_rmw = hit && !bus_wr && bus_rmw;

  AST_FLAG_HOLD_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hi |=> ((flags & $past(flags)) == $past(flags))); // R3
  AST_FLAG_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> ((flags & $past(flags & bus_wdata[DATA_W-1:BYTE_W])) ==
               $past(flags & bus_wdata[DATA_W-1:BYTE_W]))); // R3
  AST_RMW_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rmw |-> (bus_rdata[DATA_W-1:BYTE_W] == '1)); // R4
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_ch == $past(flags & enables))); // R5
  AST_ANY_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == (|irq_ch)); // R6
  AST_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo |=> $stable(enables)); // R7
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((flags & $past(rise)) == $past(rise))); // R8
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (bus_rdata == '0)); // R10
endmodule

bind eirq_latch_unit eirq_latch_unit_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .bus_rmw   (bus_rmw),
  .bus_rdata (bus_rdata),
  .rise      (rise),
  .flags     (flags),
  .enables   (enables),
  .irq_ch    (irq_ch),
  .irq_any   (irq_any)
);

// File: tb/eirq_latch_unit_tb.sv
module eirq_latch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ext_pin = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = 16'h0038;
  logic [1:0]  bus_be = 2'b00;
  logic [15:0] bus_wdata = '0;
  logic        bus_rmw = 1'b0;
  logic [15:0] bus_rdata;
  logic [7:0]  irq_ch;
  logic        irq_any;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  eirq_latch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rmw(bus_rmw), .bus_rdata(bus_rdata),
    .irq_ch(irq_ch), .irq_any(irq_any)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 2'b00;
  endtask

  task automatic rd(input logic [15:0] a, input logic rmw, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_rmw = rmw;
    #1 d = bus_rdata;
    #1 bus_sel = 1'b0; bus_rmw = 1'b0;
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); ext_pin[ch] = 1'b1;
    repeat (3) @(negedge clk);
    ext_pin[ch] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(16'h0038, 1'b0, d);
    chk("R1 reset word", d, 16'h0000);
    chk("R1 reset irq", {7'b0, irq_any, irq_ch}, 16'h0000);
  endtask

  task automatic t_latch_disabled();
    logic [15:0] d;
    @(negedge clk); ext_pin[2] = 1'b1;
    repeat (3) @(negedge clk);
    rd(16'h0038, 1'b0, d);
    chk("R2 flag after three edges", d, 16'h0400);
    ext_pin[2] = 1'b0;
    repeat (4) @(negedge clk);
    rd(16'h0038, 1'b0, d);
    chk("R2 flag held after pin falls", d, 16'h0400);
    chk("R5 no request while disabled", {7'b0, irq_any, irq_ch}, 16'h0000);
  endtask

  task automatic t_enable();
    logic [15:0] d;
    wr(16'h0038, 2'b01, 16'h0004);
    repeat (2) @(negedge clk);
    rd(16'h0038, 1'b0, d);
    chk("R9 enable keeps flag", d, 16'h0404);
    chk("R5 irq_ch gated", {8'h00, irq_ch}, 16'h0004);
    chk("R6 irq_any", {15'b0, irq_any}, 16'h0001);
  endtask

  task automatic t_clear();
    logic [15:0] d;
    pulse(5);
    wr(16'h0038, 2'b10, 16'hDF00);
    rd(16'h0038, 1'b0, d);
    chk("R3 zero clears only bit 5", d, 16'h0404);
    wr(16'h0038, 2'b10, 16'hFB00);
    repeat (2) @(negedge clk);
    rd(16'h0038, 1'b0, d);
    chk("R3 clear bit 2", d, 16'h0004);
    chk("R6 irq_any drops", {7'b0, irq_any, irq_ch}, 16'h0000);
  endtask

  task automatic t_rmw();
    logic [15:0] d;
    pulse(1);
    rd(16'h0038, 1'b1, d);
    chk("R4 rmw read ones", d, 16'hFF04);
    wr(16'h0038, 2'b11, d);
    rd(16'h0038, 1'b0, d);
    chk("R4 rmw write-back keeps flag", d, 16'h0204);
  endtask

  task automatic t_lanes();
    logic [15:0] d;
    wr(16'h0038, 2'b01, 16'h0081);
    rd(16'h0038, 1'b0, d);
    chk("R7 low lane leaves flags", d, 16'h0281);
    wr(16'h0038, 2'b10, 16'hFF00);
    rd(16'h0038, 1'b0, d);
    chk("R7 high lane leaves enables", d, 16'h0281);
    wr(16'h0038, 2'b11, 16'h0000);
    rd(16'h0038, 1'b0, d);
    chk("R3 full clear", d, 16'h0000);
  endtask

  task automatic t_level_held();
    logic [15:0] d;
    @(negedge clk); ext_pin[6] = 1'b1;
    repeat (4) @(negedge clk);
    wr(16'h0038, 2'b10, 16'h0000);
    repeat (4) @(negedge clk);
    rd(16'h0038, 1'b0, d);
    chk("R2 held level no re-set", d, 16'h0000);
    ext_pin[6] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_collision();
    logic [15:0] d;
    pulse(3);
    @(negedge clk); ext_pin[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 16'h0038; bus_be = 2'b10; bus_wdata = 16'hF700;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 2'b00;
    rd(16'h0038, 1'b0, d);
    chk("R8 edge wins over clear", d, 16'h0800);
    ext_pin[3] = 1'b0;
    wr(16'h0038, 2'b10, 16'h0000);
  endtask

  task automatic t_decode();
    logic [15:0] d;
    wr(16'h003A, 2'b11, 16'h00FF);
    rd(16'h0038, 1'b0, d);
    chk("R10 other word write ignored", d, 16'h0000);
    wr(16'h0038, 2'b01, 16'h0011);
    rd(16'h0036, 1'b0, d);
    chk("R10 other word reads zero", d, 16'h0000);
    @(negedge clk);
    bus_addr = 16'h0038; bus_sel = 1'b0;
    #1 chk("R10 unselected reads zero", bus_rdata, 16'h0000);
    wr(16'h0039, 2'b01, 16'h0000);
    rd(16'h0038, 1'b0, d);
    chk("R7 odd address same word", d, 16'h0000);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_latch_disabled();
    t_enable();
    t_clear();
    t_rmw();
    t_lanes();
    t_level_held();
    t_collision();
    t_decode();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule